// File: doc/BRIEF.md
# Single-Wire Bus Time-Slot Master

This block produces the bit-level time slots that a bus master uses on a single open-drain data line with an external pull-up. A slot is requested with a one-cycle start strobe and a 2-bit slot kind. It can write a one, write a zero, write the value on a separate write-bit input, or read a bit from the slave. The block pulls the line low for the time that the slot kind needs, then releases it. For reads, it samples the line late in the slave's answer window. It ends the slot only after the full slot period has elapsed.

The block never drives the line high. It only raises a drive-low enable, which the pad uses to pull the line down. The raw line level comes back through a synchroniser whose latency is allowed for when the read sample is taken. Every duration is a cycle-count parameter: the three low times, the sample offset and the slot period. A byte-level or command-level sequencer sits above this block and issues one slot at a time. It waits for the done pulse before it issues the next slot.

Top module: `wire_slot_master`

## Requirements
- R1: After reset, busy, done and driveLow are 0, and rdBit is 0.
- R2: A start seen while busy is 0 begins a slot. The slot kind is 2'b01 (write one), 2'b10 with wrBit=1, or 2'b00 (write zero) and 2'b10 with wrBit=0. For a write-one slot, driveLow is 1 for exactly W1L_CYC cycles, starting in the cycle after the start edge.
- R3: For a write-zero slot, driveLow is 1 for exactly W0L_CYC cycles, starting in the cycle after the start edge.
- R4: Slot kind 2'b11 is a read. driveLow is 1 for exactly RL_CYC cycles, starting in the cycle after the start edge.
- R5: driveLow is never 1 while busy is 0, and it is 0 in every cycle between slots.
- R6: A read slot returns the line level seen in slot cycle SAMPLE_CYC, where cycle 0 is the first cycle with driveLow high. A high line gives 1 and a low line gives 0. The line passes through a SYNC_STAGES-flop synchroniser, and this latency is compensated.
- R7: busy is 1 for exactly SLOT_CYC cycles. done is 1 for exactly one cycle, the first cycle after busy falls.
- R8: rdBit changes only in the cycle done is 1 after a read slot. Write slots leave it unchanged, and it holds its value until the next read slot completes.
- R9: A start that arrives while busy is 1 is ignored. The slot kind, the low time and the slot length of the running slot are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| startI | input | 1 | Start strobe for one slot |
| kindI | input | 2 | Slot kind: 00 write zero, 01 write one, 10 write wrBitI, 11 read |
| wrBitI | input | 1 | Value written when the kind is 10 |
| lineI | input | 1 | Raw level of the bus line |
| busyO | output | 1 | A slot is in progress |
| doneO | output | 1 | One-cycle pulse after the slot period ends |
| rdBitO | output | 1 | Bit returned by the last read slot |
| driveLowO | output | 1 | Enable for the pad's pull-down |

## Verification
The bench builds the block with W1L_CYC=3, RL_CYC=4, W0L_CYC=20, SAMPLE_CYC=9, SLOT_CYC=24 and two synchroniser stages. These short values make a complete slot only 24 cycles long. As a result, the randomly chosen slave hold times cover every slot cycle, including the two cycles on either side of the sample point. They also leave enough slots to try stray starts at many offsets inside a running slot.

// File: rtl/slot_pkg.sv
package slot_pkg;

  typedef enum logic [1:0] {
    KIND_W0   = 2'b00,
    KIND_W1   = 2'b01,
    KIND_WBIT = 2'b10,
    KIND_READ = 2'b11
  } slotKindE;

  // strobes from control to datapath
  typedef struct packed {
    logic launch;   // accept a new slot this edge
    logic run;      // slot in progress
    logic longLow;  // new slot uses the write-zero low time
    logic readLow;  // new slot uses the read low time
    logic capture;  // take the synchronised line level
    logic finish;   // last cycle of the slot
    logic commit;   // publish captured bit
  } slotStrbT;

endpackage

// File: rtl/slot_ctrl.sv
module slot_ctrl
  import slot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startI,
  input  logic [1:0] kindI,
  input  logic       wrBitI,
  input  logic       atSample,
  input  logic       atEnd,
  output slotStrbT   strb,
  output logic       busyO
);

  logic busyQ;
  logic readQ;
  logic isZero;
  logic isRead;

  always_comb begin
    isRead = (slotKindE'(kindI) == KIND_READ);
    isZero = (slotKindE'(kindI) == KIND_W0) ||
             ((slotKindE'(kindI) == KIND_WBIT) && !wrBitI);
    strb.launch  = !busyQ && startI;
    strb.run     = busyQ;
    strb.longLow = isZero;
    strb.readLow = isRead;
    strb.capture = busyQ && readQ && atSample;
    strb.finish  = busyQ && atEnd;
    strb.commit  = busyQ && atEnd && readQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      readQ <= 1'b0;
    end else begin
      if (strb.launch) begin
        busyQ <= 1'b1;
        readQ <= isRead;
      end else if (strb.finish) begin
        busyQ <= 1'b0;
      end
    end
  end

  assign busyO = busyQ;

  // R9
  start_busy_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !atEnd) |=> (busyQ && $stable(readQ)));

endmodule

// File: rtl/slot_dp.sv
module slot_dp
  import slot_pkg::*;
#(
  parameter int W1L_CYC     = 8,
  parameter int W0L_CYC     = 480,
  parameter int RL_CYC      = 8,
  parameter int SAMPLE_CYC  = 112,
  parameter int SLOT_CYC    = 520,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  slotStrbT strb,
  input  logic     lineI,
  output logic     atSample,
  output logic     atEnd,
  output logic     doneO,
  output logic     rdBitO,
  output logic     driveLowO
);

  localparam int CW = $clog2(SLOT_CYC + 1);
  localparam logic [CW-1:0] W1_L  = CW'(W1L_CYC);
  localparam logic [CW-1:0] W0_L  = CW'(W0L_CYC);
  localparam logic [CW-1:0] RL_L  = CW'(RL_CYC);
  localparam logic [CW-1:0] CAP_L = CW'(SAMPLE_CYC + SYNC_STAGES);
  localparam logic [CW-1:0] END_L = CW'(SLOT_CYC - 1);

  logic [CW-1:0]          cnt;
  logic [CW-1:0]          lowLen;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   driveQ;
  logic                   sampQ;
  logic                   rdQ;
  logic                   doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], lineI};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      lowLen <= W1_L;
      driveQ <= 1'b0;
      sampQ  <= 1'b0;
      rdQ    <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= strb.finish;
      if (strb.launch) begin
        cnt    <= '0;
        lowLen <= strb.longLow ? W0_L : (strb.readLow ? RL_L : W1_L);
        driveQ <= 1'b1;
      end else if (strb.run) begin
        cnt    <= cnt + 1'b1;
        driveQ <= ((cnt + 1'b1) < lowLen);
      end else begin
        driveQ <= 1'b0;
      end
      if (strb.capture) sampQ <= syncQ[SYNC_STAGES-1];
      if (strb.commit)  rdQ   <= sampQ;
    end
  end

  assign atSample  = (cnt == CAP_L);
  assign atEnd     = (cnt == END_L);
  assign doneO     = doneQ;
  assign rdBitO    = rdQ;
  assign driveLowO = driveQ;

  // R2 R3 R4
  low_time_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(driveQ) |-> (cnt == lowLen));

  // R9
  count_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.launch && !strb.finish) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/wire_slot_master.sv
module wire_slot_master
  import slot_pkg::*;
#(
  parameter int W1L_CYC     = 8,
  parameter int W0L_CYC     = 480,
  parameter int RL_CYC      = 8,
  parameter int SAMPLE_CYC  = 112,
  parameter int SLOT_CYC    = 520,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startI,
  input  logic [1:0] kindI,
  input  logic       wrBitI,
  input  logic       lineI,
  output logic       busyO,
  output logic       doneO,
  output logic       rdBitO,
  output logic       driveLowO
);

  slotStrbT strb;
  logic     atSample;
  logic     atEnd;

  initial begin
    param_order_chk: assert (RL_CYC < SAMPLE_CYC && W1L_CYC < SAMPLE_CYC &&
                             SAMPLE_CYC + SYNC_STAGES < SLOT_CYC - 1 &&
                             W0L_CYC < SLOT_CYC && SYNC_STAGES >= 2 &&
                             W1L_CYC > 0 && RL_CYC > 0);
  end

  slot_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startI   (startI),
    .kindI    (kindI),
    .wrBitI   (wrBitI),
    .atSample (atSample),
    .atEnd    (atEnd),
    .strb     (strb),
    .busyO    (busyO)
  );

  slot_dp #(
    .W1L_CYC     (W1L_CYC),
    .W0L_CYC     (W0L_CYC),
    .RL_CYC      (RL_CYC),
    .SAMPLE_CYC  (SAMPLE_CYC),
    .SLOT_CYC    (SLOT_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .lineI     (lineI),
    .atSample  (atSample),
    .atEnd     (atEnd),
    .doneO     (doneO),
    .rdBitO    (rdBitO),
    .driveLowO (driveLowO)
  );

  // R5
  drive_in_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveLowO |-> busyO);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> !doneO);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyO) |-> doneO);

  // R8
  rdbit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdBitO) |-> doneO);

endmodule

// File: tb/wire_slot_master_tb_top.sv
module wire_slot_master_tb_top;

  localparam int TW1   = 3;
  localparam int TW0   = 20;
  localparam int TRL   = 4;
  localparam int TSMP  = 9;
  localparam int TSLOT = 24;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startI = 1'b0;
  logic [1:0] kindI = 2'b00;
  logic       wrBitI = 1'b0;
  logic       slaveLow = 1'b0;
  logic       lineI;
  logic       busyO, doneO, rdBitO, driveLowO;

  int total = 0;
  int bad = 0;
  logic rdModel = 1'b0;

  always #4 clk = ~clk;

  // open-drain line with pull-up
  assign lineI = ~(driveLowO | slaveLow);

  wire_slot_master #(
    .W1L_CYC(TW1), .W0L_CYC(TW0), .RL_CYC(TRL),
    .SAMPLE_CYC(TSMP), .SLOT_CYC(TSLOT), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rstN(rstN), .startI(startI), .kindI(kindI), .wrBitI(wrBitI),
    .lineI(lineI), .busyO(busyO), .doneO(doneO), .rdBitO(rdBitO),
    .driveLowO(driveLowO)
  );

  function automatic int expLow(input logic [1:0] kind, input logic wb);
    if (kind == 2'b11) return TRL;
    if (kind == 2'b00 || (kind == 2'b10 && !wb)) return TW0;
    return TW1;
  endfunction

  function automatic logic expRead(input int holdEnd);
    return (holdEnd <= TSMP);
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idleCheck(input int n);
    int errs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (driveLowO !== 1'b0 || busyO !== 1'b0) errs++;
    end
    check(errs == 0, "R5 idle drive/busy", errs, 0);
  endtask

  task automatic runSlot(input logic [1:0] kind, input logic wb,
                         input int holdEnd, input int midAt, input string req);
    int lowLen = expLow(kind, wb);
    logic isRd = (kind == 2'b11);
    logic newModel = isRd ? expRead(holdEnd) : rdModel;
    int waveErr = 0, badK = -1, actV = 0, expV = 0;
    int rdErr = 0;
    @(negedge clk);
    startI = 1'b1; kindI = kind; wrBitI = wb;
    @(posedge clk);
    for (int k = 0; k <= TSLOT; k++) begin
      @(negedge clk);
      startI = (midAt > 0 && k == midAt);
      if (startI) begin kindI = ~kind; wrBitI = ~wb; end
      slaveLow = isRd && (k < holdEnd);
      if (driveLowO !== (k < lowLen) || busyO !== (k < TSLOT) || doneO !== (k == TSLOT)) begin
        if (badK < 0) begin
          badK = k;
          actV = {driveLowO, busyO, doneO};
          expV = {(k < lowLen), (k < TSLOT), (k == TSLOT)};
        end
        waveErr++;
      end
      if (k < TSLOT && rdBitO !== rdModel) rdErr++;
      if (k == TSLOT) check(rdBitO === newModel, {req, " R6 R8 read result"}, rdBitO, newModel);
    end
    slaveLow = 1'b0;
    startI = 1'b0;
    if (badK >= 0) $display("  first mismatch at slot cycle %0d", badK);
    check(waveErr == 0, {req, " R7 slot waveform {drive,busy,done}"}, actV, expV);
    check(rdErr == 0, "R8 rdBit held during slot", rdErr, 0);
    rdModel = newModel;
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busyO === 1'b0 && doneO === 1'b0 && driveLowO === 1'b0 && rdBitO === 1'b0,
          "R1 reset outputs", {busyO, doneO, driveLowO, rdBitO}, 0);
    rstN = 1'b1;
    idleCheck(3);

    runSlot(2'b01, 1'b0, 0, 0, "R2 write one");
    runSlot(2'b10, 1'b1, 0, 0, "R2 write bit=1");
    runSlot(2'b00, 1'b1, 0, 0, "R3 write zero");
    runSlot(2'b10, 1'b0, 0, 0, "R3 write bit=0");
    runSlot(2'b11, 1'b0, 0, 0, "R4 read, no slave hold");
    runSlot(2'b11, 1'b0, TSMP + 1, 0, "R6 hold through sample");
    runSlot(2'b01, 1'b0, 0, 0, "R8 write keeps rdBit");
    runSlot(2'b11, 1'b0, TSMP, 0, "R6 release at sample");
    runSlot(2'b11, 1'b0, TSLOT - 1, 5, "R9 start during read");
    runSlot(2'b01, 1'b1, 0, 2, "R9 start during write one");
    idleCheck(2);

    for (int n = 0; n < 60; n++) begin
      logic [1:0] kind = 2'($urandom % 4);
      logic wb = 1'($urandom % 2);
      int hold = int'($urandom % TSLOT);
      int mid = ($urandom % 3 == 0) ? int'(1 + $urandom % (TSLOT - 2)) : 0;
      runSlot(kind, wb, hold, mid, "R2 R3 R4 R9 random");
      if ($urandom % 2 == 0) idleCheck(1 + int'($urandom % 3));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule